// File: doc/BRIEF.md
# Diagnostic Loopback and Test Override Controller

This block sits between the serial-bus side of a line interface and its line transmitter and receiver. It routes two per-bit streams. The first is the stream arriving from the serial bus, which is headed for the line. The second is the stream arriving from the line, which is headed for the serial bus. Each stream is carried as a data bit plus a strobe that marks a valid bit slot. Line coding and frame generation happen elsewhere.

Diagnostic settings decide how the streams are routed and altered:
- a two-bit loopback mode;
- an all-ones transmit override;
- an override that clears echo-bit slots;
- a switch that stops the framing bit from being sent as a code violation;
- a slave-timing flag.

A host writes one shared address. A bank bit, held in bit 0 of every byte written, decides whether the next write lands in the control register or in the diagnostic register. Diagnostic changes are held as pending values. They take effect only at the next frame boundary, so a loopback never starts or ends part way through a frame.

Top module: `dlb_diag_ctrl`

## Requirements
- R1: After reset, the following hold: the control register reads 0, the bank bit is 0, and every diagnostic field is 0. The mode is therefore normal (no loopback), `fv_en` is 1, `slave_mode` is 0, and both output strobes are 0.
- R2: A write goes to the control register while the bank bit is 0 and to the diagnostic register while it is 1. Bit 0 of each written byte becomes the new bank bit and governs the next write. A write to one register leaves the other unchanged.
- R3: The diagnostic register layout is: bit 1 slave, bit 2 violation-disable, bit 3 echo-zero, bit 4 all-ones, bits 6:5 loopback mode, bit 7 ignored. A written value reaches the datapath only on the clock edge where `frame_stb` is 1. If a write and `frame_stb` fall on the same edge, the previously pending value is applied.
- R4: In mode 00 (normal), the line output carries the serial-bus input bit and strobe, and the serial-bus output carries the line input. Both outputs appear one cycle after their inputs.
- R5: In mode 01 (near-end), the line output behaves as in normal mode. The serial-bus output carries the processed transmit bit, after the echo and all-ones overrides, with the serial-bus input strobe. The line input is ignored.
- R6: In mode 10 (digital), the serial-bus output carries the raw serial-bus input, with no overrides applied. The line output behaves as in normal mode.
- R7: In mode 11 (remote), both the line output and the serial-bus output carry the line input bit and strobe.
- R8: When all-ones is set, every line output bit with its strobe high is 1 in every mode, including remote loopback.
- R9: When echo-zero is set, a serial-bus input bit whose `tx_echo_slot` is 1 is sent to the line as 0. Bits outside echo slots pass unchanged.
- R10: `fv_en` is the inverse of the applied violation-disable bit. `slave_mode` equals the applied slave bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe for the shared register address |
| host_data | input | 8 | Write data; bit 0 is the bank bit |
| frame_stb | input | 1 | Frame boundary; applies pending diagnostic settings |
| sb_rx_bit | input | 1 | Bit from the serial bus, bound for the line |
| sb_rx_stb | input | 1 | Valid strobe for sb_rx_bit |
| tx_echo_slot | input | 1 | Marks the current sb_rx bit as an echo-bit slot |
| ln_rx_bit | input | 1 | Bit from the line receiver |
| ln_rx_stb | input | 1 | Valid strobe for ln_rx_bit |
| ln_tx_bit | output | 1 | Bit to the line transmitter |
| ln_tx_stb | output | 1 | Valid strobe for ln_tx_bit |
| sb_tx_bit | output | 1 | Bit to the serial bus |
| sb_tx_stb | output | 1 | Valid strobe for sb_tx_bit |
| fv_en | output | 1 | Framing-bit code violation enable |
| slave_mode | output | 1 | External timing select |
| ctrl_q | output | 8 | Control register contents |

## Verification
The bench writes a remote-loopback setting and drives traffic before any frame boundary. A design that applies settings straight from the write would loop traffic early. The bench sets all-ones together with remote loopback, where a wrong priority would let a received 0 reach the line. It also drives an echo slot in near-end and in digital loopback, so a design that takes the looped stream from the wrong point shows a cleared bit in one case or a set bit in the other. The bench flips the bank bit back and forth and checks that the register not selected holds its value; a design that decodes the bank from the current byte rather than the stored one would corrupt the control register.

// File: rtl/dlb_pkg.sv
package dlb_pkg;

    localparam int REG_W      = 8;
    localparam int BANK_BIT   = 0;
    localparam int SLAVE_BIT  = 1;
    localparam int NOVIOL_BIT = 2;
    localparam int ECHO_BIT   = 3;
    localparam int ONES_BIT   = 4;
    localparam int MODE_LSB   = 5;
    localparam int MODE_W     = 2;

    typedef enum logic [MODE_W-1:0] {
        LB_NONE    = 2'b00,
        LB_NEAR    = 2'b01,
        LB_DIGITAL = 2'b10,
        LB_REMOTE  = 2'b11
    } lb_mode_e;

    typedef struct packed {
        lb_mode_e mode;
        logic     all_ones;
        logic     echo_zero;
        logic     no_viol;
        logic     slave;
    } diag_cfg_t;

    typedef struct packed {
        logic bit_v;
        logic stb;
    } bitstrm_t;

endpackage

// File: rtl/dlb_regfile.sv
module dlb_regfile
    import dlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic [REG_W-1:0] host_data,
    input  logic             frame_stb,
    output logic [REG_W-1:0] ctrl_q,
    output diag_cfg_t        active_cfg
);

    logic      bank_q;
    diag_cfg_t pend_q;
    diag_cfg_t decoded;

    always_comb begin
        decoded.mode      = lb_mode_e'(host_data[MODE_LSB +: MODE_W]);
        decoded.all_ones  = host_data[ONES_BIT];
        decoded.echo_zero = host_data[ECHO_BIT];
        decoded.no_viol   = host_data[NOVIOL_BIT];
        decoded.slave     = host_data[SLAVE_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q     <= 1'b0;
            ctrl_q     <= '0;
            pend_q     <= '0;
            active_cfg <= '0;
        end else begin
            if (host_wr) begin
                bank_q <= host_data[BANK_BIT];
                if (bank_q) pend_q <= decoded;
                else        ctrl_q <= host_data;
            end
            if (frame_stb) active_cfg <= pend_q;
        end
    end

    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!host_wr || bank_q) |=> $stable(ctrl_q));

    p_pend_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!host_wr || !bank_q) |=> $stable(pend_q));

    p_frame_only_r3: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(active_cfg));

endmodule

// File: rtl/dlb_path.sv
module dlb_path
    import dlb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  diag_cfg_t cfg,
    input  bitstrm_t  sb_in,
    input  logic      echo_slot,
    input  bitstrm_t  ln_in,
    output bitstrm_t  ln_tx,
    output bitstrm_t  sb_tx
);

    bitstrm_t tx_proc;
    bitstrm_t ln_nxt;
    bitstrm_t sb_nxt;

    always_comb begin
        // transmit-side processing of the serial-bus stream
        tx_proc.stb   = sb_in.stb;
        tx_proc.bit_v = sb_in.bit_v & ~(echo_slot & cfg.echo_zero);

        ln_nxt = (cfg.mode == LB_REMOTE) ? ln_in : tx_proc;
        if (cfg.all_ones) ln_nxt.bit_v = 1'b1;

        unique case (cfg.mode)
            LB_NEAR:    sb_nxt = ln_nxt;
            LB_DIGITAL: sb_nxt = sb_in;
            default:    sb_nxt = ln_in;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ln_tx <= '0;
            sb_tx <= '0;
        end else begin
            ln_tx <= ln_nxt;
            sb_tx <= sb_nxt;
        end
    end

    p_ones_prio_r8: assert property (@(posedge clk) disable iff (rst)
        cfg.all_ones |=> (!ln_tx.stb || ln_tx.bit_v));

    p_echo_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (sb_in.stb && echo_slot && cfg.echo_zero && !cfg.all_ones && cfg.mode != LB_REMOTE)
        |=> (ln_tx.stb && !ln_tx.bit_v));

    p_remote_loop_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == LB_REMOTE && !cfg.all_ones) |=> (ln_tx == $past(ln_in)));

    p_digital_loop_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == LB_DIGITAL) |=> (sb_tx == $past(sb_in)));

endmodule

// File: rtl/dlb_diag_ctrl.sv
module dlb_diag_ctrl
    import dlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic [REG_W-1:0] host_data,
    input  logic             frame_stb,
    input  logic             sb_rx_bit,
    input  logic             sb_rx_stb,
    input  logic             tx_echo_slot,
    input  logic             ln_rx_bit,
    input  logic             ln_rx_stb,
    output logic             ln_tx_bit,
    output logic             ln_tx_stb,
    output logic             sb_tx_bit,
    output logic             sb_tx_stb,
    output logic             fv_en,
    output logic             slave_mode,
    output logic [REG_W-1:0] ctrl_q
);

    diag_cfg_t cfg;
    bitstrm_t  sb_in, ln_in, ln_tx, sb_tx;

    assign sb_in = '{bit_v: sb_rx_bit, stb: sb_rx_stb};
    assign ln_in = '{bit_v: ln_rx_bit, stb: ln_rx_stb};

    dlb_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_data  (host_data),
        .frame_stb  (frame_stb),
        .ctrl_q     (ctrl_q),
        .active_cfg (cfg)
    );

    dlb_path u_path (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .sb_in     (sb_in),
        .echo_slot (tx_echo_slot),
        .ln_in     (ln_in),
        .ln_tx     (ln_tx),
        .sb_tx     (sb_tx)
    );

    assign ln_tx_bit  = ln_tx.bit_v;
    assign ln_tx_stb  = ln_tx.stb;
    assign sb_tx_bit  = sb_tx.bit_v;
    assign sb_tx_stb  = sb_tx.stb;
    assign fv_en      = ~cfg.no_viol;
    assign slave_mode = cfg.slave;

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (ctrl_q == '0 && fv_en && !slave_mode && !ln_tx_stb && !sb_tx_stb));

endmodule

// File: tb/dlb_diag_ctrl_test.sv
`timescale 1ns/1ps
module dlb_diag_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic [7:0] host_data = '0;
    logic       frame_stb = 1'b0;
    logic       sb_rx_bit = 1'b0, sb_rx_stb = 1'b0, tx_echo_slot = 1'b0;
    logic       ln_rx_bit = 1'b0, ln_rx_stb = 1'b0;
    logic       ln_tx_bit, ln_tx_stb, sb_tx_bit, sb_tx_stb, fv_en, slave_mode;
    logic [7:0] ctrl_q;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dlb_diag_ctrl uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_data(host_data),
        .frame_stb(frame_stb), .sb_rx_bit(sb_rx_bit), .sb_rx_stb(sb_rx_stb),
        .tx_echo_slot(tx_echo_slot), .ln_rx_bit(ln_rx_bit), .ln_rx_stb(ln_rx_stb),
        .ln_tx_bit(ln_tx_bit), .ln_tx_stb(ln_tx_stb), .sb_tx_bit(sb_tx_bit),
        .sb_tx_stb(sb_tx_stb), .fv_en(fv_en), .slave_mode(slave_mode), .ctrl_q(ctrl_q)
    );

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] d);
        host_wr = 1'b1; host_data = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic frame_pulse();
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    // drive one bit slot on each stream and wait one cycle for the registered outputs
    task automatic slot(input logic sb, input logic sbs, input logic echo,
                        input logic ln, input logic lns);
        sb_rx_bit = sb; sb_rx_stb = sbs; tx_echo_slot = echo;
        ln_rx_bit = ln; ln_rx_stb = lns;
        @(negedge clk);
    endtask

    task automatic idle();
        sb_rx_stb = 1'b0; ln_rx_stb = 1'b0; tx_echo_slot = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ctrl_q after reset", ctrl_q, 8'h00);
        chk("R1 fv_en after reset", {7'd0, fv_en}, 8'h01);
        chk("R1 slave after reset", {7'd0, slave_mode}, 8'h00);
        chk("R1 strobes after reset", {6'd0, ln_tx_stb, sb_tx_stb}, 8'h00);
        slot(1, 1, 0, 0, 1);
        chk("R1 default no loopback", {6'd0, ln_tx_bit, sb_tx_bit}, 8'h02);
    endtask

    task automatic t_normal();
        slot(0, 1, 0, 1, 1);
        chk("R4 normal pass 0/1", {4'd0, ln_tx_bit, ln_tx_stb, sb_tx_bit, sb_tx_stb}, 8'h07);
        slot(1, 1, 0, 0, 0);
        chk("R4 normal strobe gating", {4'd0, ln_tx_bit, ln_tx_stb, sb_tx_bit, sb_tx_stb}, 8'h0C);
        slot(1, 1, 1, 1, 1);
        chk("R9 echo slot untouched when echo-zero clear", {7'd0, ln_tx_bit}, 8'h01);
        idle();
    endtask

    task automatic t_bank();
        host_write(8'hA4);
        chk("R2 control write bank 0", ctrl_q, 8'hA4);
        host_write(8'h01);
        chk("R2 control write sets bank", ctrl_q, 8'h01);
        host_write(8'h11);
        chk("R2 diag write leaves control", ctrl_q, 8'h01);
        host_write(8'h00);
        host_write(8'h5A);
        chk("R2 back to control bank", ctrl_q, 8'h5A);
        frame_pulse();
        slot(0, 1, 0, 0, 0);
        chk("R2 diag cleared by later diag write", {6'd0, ln_tx_bit, ln_tx_stb}, 8'h01);
        host_write(8'h01);
    endtask

    task automatic t_frame();
        host_write(8'h65);  // remote loopback, violation-disable, bank stays 1
        slot(1, 1, 0, 0, 1);
        chk("R3 not applied before frame", {6'd0, ln_tx_bit, sb_tx_bit}, 8'h02);
        chk("R3 fv_en unchanged before frame", {7'd0, fv_en}, 8'h01);
        frame_pulse();
        chk("R10 fv_en after violation-disable", {7'd0, fv_en}, 8'h00);
        slot(1, 1, 0, 0, 1);
        chk("R3 applied after frame", {6'd0, ln_tx_bit, ln_tx_stb}, 8'h01);
    endtask

    task automatic t_remote();
        slot(1, 0, 0, 1, 1);
        chk("R7 remote ln_tx follows line", {4'd0, ln_tx_bit, ln_tx_stb, sb_tx_bit, sb_tx_stb}, 8'h0F);
        slot(1, 1, 0, 0, 0);
        chk("R7 remote ignores bus strobe", {6'd0, ln_tx_stb, sb_tx_stb}, 8'h00);
    endtask

    task automatic t_ones();
        host_write(8'h71);
        frame_pulse();
        slot(0, 0, 0, 0, 1);
        chk("R8 all-ones over remote", {4'd0, ln_tx_bit, ln_tx_stb, sb_tx_bit, sb_tx_stb}, 8'h0D);
    endtask

    task automatic t_near();
        host_write(8'h29);
        frame_pulse();
        slot(1, 1, 1, 1, 1);
        chk("R5 near-end echo slot", {4'd0, ln_tx_bit, ln_tx_stb, sb_tx_bit, sb_tx_stb}, 8'h05);
        slot(1, 1, 0, 0, 1);
        chk("R5 near-end data bit", {4'd0, ln_tx_bit, ln_tx_stb, sb_tx_bit, sb_tx_stb}, 8'h0F);
    endtask

    task automatic t_digital();
        host_write(8'h49);
        frame_pulse();
        slot(1, 1, 1, 0, 1);
        chk("R6 digital raw to bus", {4'd0, ln_tx_bit, ln_tx_stb, sb_tx_bit, sb_tx_stb}, 8'h07);
    endtask

    task automatic t_echo();
        host_write(8'h09);
        frame_pulse();
        slot(1, 1, 1, 0, 0);
        chk("R9 echo slot cleared", {6'd0, ln_tx_bit, ln_tx_stb}, 8'h01);
        slot(1, 1, 0, 0, 0);
        chk("R9 non-echo bit kept", {6'd0, ln_tx_bit, ln_tx_stb}, 8'h03);
    endtask

    task automatic t_flags();
        host_write(8'h03);
        chk("R10 slave not before frame", {7'd0, slave_mode}, 8'h00);
        frame_pulse();
        chk("R10 slave applied", {7'd0, slave_mode}, 8'h01);
        chk("R10 fv_en with violation-disable clear", {7'd0, fv_en}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_normal();
        t_bank();
        t_frame();
        t_remote();
        t_ones();
        t_near();
        t_digital();
        t_echo();
        t_flags();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule